// File: doc/BRIEF.md
# Transport Clock Recovery Loop

This block rebuilds a transport stream's 27 MHz system time clock at the receiver. A stream receiver hands it each Program Clock Reference (a 33-bit base counted in 90 kHz units plus a 9-bit extension counted in 27 MHz ticks) with a one-cycle strobe. The block runs its own system time clock counter on the local oscillator clock. The first reference after the loop is enabled seeds that counter. Every later reference is compared with a snapshot of the counter. The difference is smoothed by a proportional-plus-integral filter and turned into a 1-bit sigma-delta bitstream that steers an external voltage-controlled crystal oscillator.

Software reaches the block through a small word-addressed register port. Through it, software enables the loop, sets the two filter gains and reads the live counter, the snapshot, the last reference, the seed value, the error and the filter state. It also controls an interrupt pair made of enable and status bits.

Top module: `pcr_clk_recovery`

## Requirements
- R1: After reset every readable register reads 0, `irq` is 0 and, with a zero filter output, `vcxo_sd` produces exactly 32 ones in any 64 consecutive cycles.
- R2: While enabled (CTRL bit 0), the counter extension steps 0 to 299 once per clock. A wrap from 299 to 0 increments the 33-bit base modulo 2^33. While disabled the counter holds its value.
- R3: Register map (word address, 1-cycle read latency): 0 CTRL, 1 GAIN (bits 4:0 proportional shift, bits 12:8 integral shift), 2/3 live counter, 4/5 snapshot, 6/7 last reference, 8/9 seed, 10 error, 11 integrator, 12 filter output, 13 interrupt enable (read; write sets), 14 enable clear (write), 15 status (read; write 1 clears). A high word holds base[32:16] in bits 16:0. A low word holds base[15:0] in bits 24:9 and the extension in bits 8:0. Signed values are sign-extended to 32 bits.
- R4: A strobe while enabled stores the reference value and the counter value of that cycle. A strobe while disabled changes nothing.
- R5: The first strobe after enable loads the counter with the reference (it reads back exactly on the next cycle), stores it as the seed, sets status bit 1 and leaves the error unchanged.
- R6: Every later strobe produces the error in 27 MHz ticks: the base difference is taken modulo 2^33 as a signed value, multiplied by 300, and the extension difference is added. The result saturates to a 24-bit signed range.
- R7: The integrator adds the error shifted right arithmetically by the integral shift and saturates to 24-bit signed. The output is the error shifted by the proportional shift plus the new integrator, saturated to 16-bit signed.
- R8: The modulator adds the filter output, offset by 2^15, into a 16-bit accumulator and emits the carry. Over N cycles the ones count differs from N·u/2^16 by less than 1.
- R9: Status bit 0 sets on every accepted strobe. Writing 1 to a status bit clears it. `irq` is high when any status bit has its enable bit set.
- R10: Clearing the enable stops the counter and re-arms seeding, so the next strobe after re-enable loads the counter and the seed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock (27 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| pcr_stb | input | 1 | One-cycle strobe marking a received reference |
| pcr_base | input | 33 | Reference base value |
| pcr_ext | input | 9 | Reference extension value (0 to 299) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| irq | output | 1 | Interrupt request |
| vcxo_sd | output | 1 | Sigma-delta bitstream for the oscillator control |

## Verification
The assertions assume that the reference extension never exceeds 299, so the counter's extension field stays within range after seeding. They also assume that strobes are single-cycle pulses. The stimulus only produces extensions in range, fires each strobe for exactly one cycle, and keeps at least three idle cycles between strobes and before any read of the error or filter registers, so each result has settled through the error and filter stages. The reference values are chosen to cross the 2^33 base wrap and to drive the error to both saturation limits.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int BASE_W   = 33;
  localparam int EXT_W    = 9;
  localparam int EXT_LAST = 299;
  localparam int TICKS    = EXT_LAST + 1;
  localparam int CALC_W   = 48;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [EXT_W-1:0]  ext;
  } stc_t;

  typedef enum logic [3:0] {
    A_CTRL = 4'd0, A_GAIN = 4'd1, A_STC_H = 4'd2, A_STC_L = 4'd3,
    A_SNP_H = 4'd4, A_SNP_L = 4'd5, A_REF_H = 4'd6, A_REF_L = 4'd7,
    A_SEED_H = 4'd8, A_SEED_L = 4'd9, A_ERR = 4'd10, A_INTEG = 4'd11,
    A_FILT = 4'd12, A_IEN = 4'd13, A_IEN_CLR = 4'd14, A_ISTAT = 4'd15
  } reg_addr_e;
endpackage

// File: rtl/stc_counter.sv
module stc_counter
  import pcr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic load,
  input  stc_t load_val,
  output stc_t cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run) begin
      if (cnt.ext == EXT_W'(EXT_LAST)) begin
        cnt.ext  <= '0;
        cnt.base <= cnt.base + 1'b1;
      end else begin
        cnt.ext <= cnt.ext + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcr_err_calc.sv
module pcr_err_calc
  import pcr_pkg::*;
#(
  parameter int ERR_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  stc_t                    ref_val,
  input  stc_t                    snap_val,
  output logic signed [ERR_W-1:0] err,
  output logic                    err_v
);
  localparam logic signed [CALC_W-1:0] EMAX = (CALC_W'(1) <<< (ERR_W-1)) - 1;
  localparam logic signed [CALC_W-1:0] EMIN = -(CALC_W'(1) <<< (ERR_W-1));

  logic [BASE_W-1:0]         db;
  logic signed [CALC_W-1:0]  db_s, de_s, tick_diff;

  always_comb begin
    db        = ref_val.base - snap_val.base;
    db_s      = CALC_W'($signed(db));
    de_s      = CALC_W'($signed({1'b0, ref_val.ext})) - CALC_W'($signed({1'b0, snap_val.ext}));
    tick_diff = db_s * CALC_W'(TICKS) + de_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err   <= '0;
      err_v <= 1'b0;
    end else begin
      err_v <= go;
      if (go) begin
        if (tick_diff > EMAX)      err <= EMAX[ERR_W-1:0];
        else if (tick_diff < EMIN) err <= EMIN[ERR_W-1:0];
        else                       err <= tick_diff[ERR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pcr_loop_filter.sv
module pcr_loop_filter
  import pcr_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int INT_W = 24,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd,
  input  logic signed [ERR_W-1:0] err,
  input  logic [4:0]              kp_sh,
  input  logic [4:0]              ki_sh,
  output logic signed [INT_W-1:0] integ,
  output logic signed [OUT_W-1:0] filt
);
  localparam logic signed [CALC_W-1:0] IMAX = (CALC_W'(1) <<< (INT_W-1)) - 1;
  localparam logic signed [CALC_W-1:0] IMIN = -(CALC_W'(1) <<< (INT_W-1));
  localparam logic signed [CALC_W-1:0] OMAX = (CALC_W'(1) <<< (OUT_W-1)) - 1;
  localparam logic signed [CALC_W-1:0] OMIN = -(CALC_W'(1) <<< (OUT_W-1));

  logic signed [CALC_W-1:0] e_w, isum, inext_w, osum;
  logic signed [INT_W-1:0]  inext;
  logic signed [OUT_W-1:0]  onext;

  always_comb begin
    e_w  = CALC_W'(err);
    isum = CALC_W'(integ) + (e_w >>> ki_sh);
    if (isum > IMAX)      inext_w = IMAX;
    else if (isum < IMIN) inext_w = IMIN;
    else                  inext_w = isum;
    inext = inext_w[INT_W-1:0];
    osum  = (e_w >>> kp_sh) + inext_w;
    if (osum > OMAX)      onext = OMAX[OUT_W-1:0];
    else if (osum < OMIN) onext = OMIN[OUT_W-1:0];
    else                  onext = osum[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ <= '0;
      filt  <= '0;
    end else if (upd) begin
      integ <= inext;
      filt  <= onext;
    end
  end
endmodule

// File: rtl/sd_dac.sv
module sd_dac #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] level,
  output logic                bit_out
);
  logic [W-1:0] acc, u;
  logic [W:0]   sum;

  always_comb begin
    u   = {~level[W-1], level[W-2:0]};
    sum = {1'b0, acc} + {1'b0, u};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      bit_out <= 1'b0;
    end else begin
      acc     <= sum[W-1:0];
      bit_out <= sum[W];
    end
  end
endmodule

// File: rtl/pcr_clk_recovery.sv
module pcr_clk_recovery
  import pcr_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int INT_W = 24,
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pcr_stb,
  input  logic [32:0]       pcr_base,
  input  logic [8:0]        pcr_ext,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              vcxo_sd
);
  logic       en_q, seeded;
  logic [4:0] kp_q, ki_q;
  logic [1:0] ien_q, ist_q, ist_set, ist_clr;
  stc_t       stc_cur, ref_q, snap_q, seed_q, ref_in;
  logic       accept, load_stc, calc_go;
  logic signed [ERR_W-1:0] err_q;
  logic                    err_v;
  logic signed [INT_W-1:0] integ_q;
  logic signed [OUT_W-1:0] filt_q;
  logic [31:0]             rd_mux;

  assign ref_in   = '{base: pcr_base, ext: pcr_ext};
  assign accept   = pcr_stb && en_q;
  assign load_stc = accept && !seeded;
  assign ist_set  = {load_stc, accept};
  assign ist_clr  = (reg_we && reg_addr == A_ISTAT) ? reg_wdata[1:0] : 2'b00;

  stc_counter u_stc (
    .clk(clk), .rst(rst), .run(en_q), .load(load_stc),
    .load_val(ref_in), .cnt(stc_cur)
  );

  pcr_err_calc #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .go(calc_go), .ref_val(ref_q),
    .snap_val(snap_q), .err(err_q), .err_v(err_v)
  );

  pcr_loop_filter #(.ERR_W(ERR_W), .INT_W(INT_W), .OUT_W(OUT_W)) u_lf (
    .clk(clk), .rst(rst), .upd(err_v), .err(err_q),
    .kp_sh(kp_q), .ki_sh(ki_q), .integ(integ_q), .filt(filt_q)
  );

  sd_dac #(.W(OUT_W)) u_sd (
    .clk(clk), .rst(rst), .level(filt_q), .bit_out(vcxo_sd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; seeded <= 1'b0; kp_q <= '0; ki_q <= '0;
      ien_q <= '0; ist_q <= '0; calc_go <= 1'b0; irq <= 1'b0;
      ref_q <= '0; snap_q <= '0; seed_q <= '0;
    end else begin
      calc_go <= accept && seeded;
      ist_q   <= (ist_q & ~ist_clr) | ist_set;
      irq     <= |(ist_q & ien_q);
      if (accept) begin
        ref_q  <= ref_in;
        snap_q <= stc_cur;
      end
      if (load_stc) begin
        seed_q <= ref_in;
        seeded <= 1'b1;
      end
      if (!en_q) seeded <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          A_CTRL:    en_q  <= reg_wdata[0];
          A_GAIN:    begin kp_q <= reg_wdata[4:0]; ki_q <= reg_wdata[12:8]; end
          A_IEN:     ien_q <= ien_q | reg_wdata[1:0];
          A_IEN_CLR: ien_q <= ien_q & ~reg_wdata[1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:   rd_mux = {31'b0, en_q};
      A_GAIN:   rd_mux = {19'b0, ki_q, 3'b0, kp_q};
      A_STC_H:  rd_mux = 32'(stc_cur.base[32:16]);
      A_STC_L:  rd_mux = 32'({stc_cur.base[15:0], stc_cur.ext});
      A_SNP_H:  rd_mux = 32'(snap_q.base[32:16]);
      A_SNP_L:  rd_mux = 32'({snap_q.base[15:0], snap_q.ext});
      A_REF_H:  rd_mux = 32'(ref_q.base[32:16]);
      A_REF_L:  rd_mux = 32'({ref_q.base[15:0], ref_q.ext});
      A_SEED_H: rd_mux = 32'(seed_q.base[32:16]);
      A_SEED_L: rd_mux = 32'({seed_q.base[15:0], seed_q.ext});
      A_ERR:    rd_mux = 32'(err_q);
      A_INTEG:  rd_mux = 32'(integ_q);
      A_FILT:   rd_mux = 32'(filt_q);
      A_IEN:    rd_mux = {30'b0, ien_q};
      A_ISTAT:  rd_mux = {30'b0, ist_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pcr_clk_recovery_chk.sv
module pcr_clk_recovery_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        stb,
  input logic        ld,
  input logic        seeded,
  input logic [8:0]  c_ext,
  input logic [32:0] c_base,
  input logic [8:0]  r_ext,
  input logic [32:0] r_base,
  input logic [32:0] s_base,
  input logic [1:0]  ist,
  input logic        irq
);
  a_r2_ext_range: assert property (@(posedge clk) disable iff (rst)
    c_ext <= 9'd299);
  a_r2_ext_step: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && c_ext != 9'd299) |=> (c_ext == $past(c_ext) + 9'd1));
  a_r2_base_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && c_ext == 9'd299) |=> (c_ext == 9'd0 && c_base == $past(c_base) + 33'd1));
  a_r2_hold_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(c_ext) && $stable(c_base)));
  a_r4_ignore_off: assert property (@(posedge clk) disable iff (rst)
    (stb && !en) |=> ($stable(r_ext) && $stable(r_base)));
  a_r5_seed_kept: assert property (@(posedge clk) disable iff (rst)
    (seeded && en) |=> $stable(s_base));
  a_r9_quiet_irq: assert property (@(posedge clk) disable iff (rst)
    (ist == 2'b00) |=> !irq);
endmodule

bind pcr_clk_recovery pcr_clk_recovery_chk u_chk (
  .clk(clk), .rst(rst), .en(en_q), .stb(pcr_stb), .ld(load_stc),
  .seeded(seeded), .c_ext(stc_cur.ext), .c_base(stc_cur.base),
  .r_ext(ref_q.ext), .r_base(ref_q.base), .s_base(seed_q.base),
  .ist(ist_q), .irq(irq)
);

// File: tb/pcr_clk_recovery_bench.sv
module pcr_clk_recovery_bench;
  localparam longint TWO33 = 64'sd1 << 33;
  localparam longint MODT  = TWO33 * 300;

  logic        clk = 1'b0, rst = 1'b1;
  logic        pcr_stb = 1'b0, reg_we = 1'b0;
  logic [32:0] pcr_base = '0;
  logic [8:0]  pcr_ext = '0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, vcxo_sd;

  pcr_clk_recovery u_pcr_clk_recovery (.*);

  always #10 clk = ~clk;

  typedef struct { logic [3:0] a; logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int nchk = 0, nfail = 0, cyc = 0;
  logic rd_req = 1'b0, rd_seen = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_seen <= rd_req;
  end

  task automatic check(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each issued read
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) check("scoreboard underflow", 1, 0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, reg_rdata, it.exp);
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic rd_expect(logic [3:0] a, logic [31:0] e, string tag);
    item_t it;
    it.a = a; it.exp = e; it.tag = tag;
    reg_addr = a; rd_req = 1'b1; sb_q.push_back(it);
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic rd_raw(logic [3:0] a, output logic [31:0] v);
    reg_addr = a; @(negedge clk); v = reg_rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] hi_w(longint t);
    return 32'((t / 300) >> 16);
  endfunction
  function automatic logic [31:0] lo_w(longint t);
    return 32'((((t / 300) & 64'hFFFF) << 9) | (t % 300));
  endfunction

  // reference model state
  logic   en_m = 1'b0, seeded_m = 1'b0;
  longint seed_t = 0, integ_m = 0, err_m = 0, filt_m = 0, snap_t = 0;
  int     c0 = 0, kp_m = 0, ki_m = 0;

  function automatic longint sat(longint v, int w);
    longint mx, mn;
    mx = (64'sd1 <<< (w-1)) - 1; mn = -(64'sd1 <<< (w-1));
    return (v > mx) ? mx : ((v < mn) ? mn : v);
  endfunction

  task automatic strobe(longint b, longint e);
    longint t, db;
    int edge_c;
    t = b * 300 + e; edge_c = cyc + 1;
    pcr_base = 33'(b); pcr_ext = 9'(e); pcr_stb = 1'b1;
    if (en_m) begin
      if (!seeded_m) begin
        seeded_m = 1'b1; seed_t = t; c0 = edge_c;
      end else begin
        snap_t = (seed_t + longint'(edge_c - 1 - c0)) % MODT;
        db = (b - snap_t / 300) & (TWO33 - 1);
        if (db >= TWO33 / 2) db -= TWO33;
        err_m   = sat(db * 300 + e - snap_t % 300, 24);
        integ_m = sat(integ_m + (err_m >>> ki_m), 24);
        filt_m  = sat((err_m >>> kp_m) + integ_m, 16);
      end
    end
    @(negedge clk); pcr_stb = 1'b0;
  endtask

  task automatic density(int n, longint level, string tag);
    longint ones, u, d;
    ones = 0; u = level + 32768;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ones += vcxo_sd;
    end
    d = ones * 65536 - longint'(n) * u;
    check(tag, (d > -65536 && d < 65536) ? 1 : 0, 1);
  endtask

  bit done = 1'b0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      check("watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    idle(5); rst = 1'b0; @(negedge clk);
    // R1 reset state
    rd_expect(4'd0, 0, "R1 CTRL"); rd_expect(4'd3, 0, "R1 STC low");
    rd_expect(4'd15, 0, "R1 status"); rd_expect(4'd12, 0, "R1 filter");
    check("R1 irq", irq, 0);
    density(64, 0, "R1 R8 mid-scale bitstream");
    // R4 strobe ignored while disabled
    strobe(33'h0ABCD, 17); idle(3);
    rd_expect(4'd7, 0, "R4 ref low unchanged"); rd_expect(4'd6, 0, "R4 ref high unchanged");
    rd_expect(4'd15, 0, "R4 status unchanged"); rd_expect(4'd3, 0, "R2 counter held off");
    // configure (R3 gain fields)
    wr(4'd1, 32'h0000_0604); kp_m = 4; ki_m = 6;
    rd_expect(4'd1, 32'h0000_0604, "R3 gain readback");
    wr(4'd13, 3); wr(4'd0, 1); en_m = 1'b1;
    // R5 seed near the base wrap, R2 counting and wrap
    strobe(TWO33 - 1, 298);
    rd_expect(4'd3, lo_w((TWO33 - 1) * 300 + 298), "R5 counter loaded");
    rd_expect(4'd3, lo_w((TWO33 - 1) * 300 + 299), "R2 extension step");
    rd_expect(4'd3, 0, "R2 extension and base wrap");
    rd_expect(4'd2, 0, "R2 base modulo 2^33");
    rd_expect(4'd8, 32'h1FFFF, "R5 seed high"); rd_expect(4'd9, lo_w(seed_t), "R5 seed low");
    rd_expect(4'd6, 32'h1FFFF, "R4 ref high"); rd_expect(4'd15, 3, "R9 status both");
    rd_expect(4'd10, 0, "R5 no error on seed");
    check("R9 irq raised", irq, 1);
    idle(40);
    // R6 error across the wrap
    strobe(5, 10); idle(3);
    rd_expect(4'd4, hi_w(snap_t), "R4 snapshot high"); rd_expect(4'd5, lo_w(snap_t), "R4 snapshot low");
    rd_expect(4'd10, 32'(err_m), "R6 wrap error");
    rd_expect(4'd11, 32'(integ_m), "R7 integrator");
    rd_expect(4'd12, 32'(filt_m), "R7 filter output");
    // R6 positive saturation
    strobe(5 + (64'sd1 << 20), 0); idle(3);
    rd_expect(4'd10, 32'h007F_FFFF, "R6 positive saturation");
    rd_expect(4'd12, 32'(filt_m), "R7 output saturation");
    // R7 integrator saturation with zero integral shift
    wr(4'd1, 32'h0000_0004); ki_m = 0;
    strobe(5 + (64'sd1 << 20), 0); idle(3);
    strobe(5 + (64'sd1 << 20), 0); idle(3);
    rd_expect(4'd11, 32'h007F_FFFF, "R7 integrator ceiling");
    check("R7 model ceiling", integ_m, 8388607);
    density(1024, filt_m, "R8 full-scale density");
    // negative saturation
    strobe(TWO33 - (64'sd1 << 20), 0); idle(3);
    rd_expect(4'd10, 32'hFF80_0000, "R6 negative saturation");
    rd_expect(4'd11, 32'(integ_m), "R7 integrator after negative");
    rd_expect(4'd12, 32'hFFFF_8000, "R7 negative output limit");
    density(256, filt_m, "R8 zero-scale density");
    // R9 interrupts
    wr(4'd15, 1); rd_expect(4'd15, 2, "R9 clear bit 0");
    wr(4'd14, 2); rd_expect(4'd13, 1, "R9 enable clear"); idle(2);
    check("R9 irq masked", irq, 0);
    wr(4'd15, 2); rd_expect(4'd15, 0, "R9 clear bit 1");
    // R10 disable stops counter and re-arms seeding
    wr(4'd0, 0); en_m = 1'b0; seeded_m = 1'b0; idle(2);
    rd_raw(4'd3, v1); idle(5); rd_raw(4'd3, v2);
    check("R10 counter stopped", v2, v1);
    wr(4'd0, 1); en_m = 1'b1;
    strobe(123, 7);
    rd_expect(4'd3, lo_w(123 * 300 + 7), "R10 reload");
    rd_expect(4'd9, lo_w(123 * 300 + 7), "R10 seed low"); rd_expect(4'd15, 3, "R10 status");
    idle(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule